// File: doc/BRIEF.md
# Processor status flag register

This block is the 8-bit status register of a small 8-bit CPU core. It keeps the four arithmetic result flags (negative, overflow, zero, carry) and the two program-controlled mode bits (decimal and interrupt-disable). It also presents two fixed bits: a user bit and a break bit.

Four sources can write it:
- the ALU, through per-flag write strobes;
- the instruction decoder, through set and clear commands for the two mode bits;
- the stack, through a whole-byte load when status is pulled;
- an external active-low set-overflow pin. This pin is asynchronous, so it is synchronized and edge-detected before it sets the overflow flag.

A second output carries the byte to be pushed on the stack. Its break bit tells a software break apart from a hardware interrupt.

Reset sets only the mode bits. The arithmetic flags keep whatever they held, and software is expected to initialize them.

Top module: `cpu_status_reg`

## Requirements
- R1: `flags_o` has this bit layout:

  | Bit | Content |
  |-----|---------|
  | 7 | N |
  | 6 | V |
  | 5 | user bit, always reads 1 |
  | 4 | B, always reads 1 |
  | 3 | D |
  | 2 | I |
  | 1 | Z |
  | 0 | C |

- R2: While `rst_n` is low, D reads 0 and I reads 1 from the first clock edge. N, V, Z and C are not changed by reset and keep their previous values.
- R3: `alu_we` and `alu_val` are ordered {N,V,Z,C}, from bit 3 down to bit 0. On a clock edge, each flag whose strobe is 1 takes the matching value. Flags whose strobe is 0 keep their value.
- R4: `i_set` and `i_clr` control I, and `d_set` and `d_clr` control D. The new value shows after the next clock edge. If set and clear of the same bit are both asserted, set wins.
- R5: `pull_load` writes N, V, D, I, Z and C from `pull_data` at the same bit positions as in R1. Bits 5 and 4 of `pull_data` are ignored. In the same cycle, a pull overrides ALU strobes and mode commands.
- R6: A falling edge on `so_n` sets V. `so_n` passes through two synchronizer stages, so if it is first sampled low at clock edge k, V reads 1 after edge k+2 and still 0 after edge k+1. Holding `so_n` low sets V only once: after software clears V, V stays 0.
- R7: If an overflow-pin edge takes effect in the same cycle as an ALU write of V or a pull, V becomes 1. All other bits follow the ALU write or the pull as usual.
- R8: `push_img_o` equals `flags_o` except bit 4, which equals `push_brk`. `push_brk` is 1 for a software break and 0 for a hardware interrupt.
- R9: With no strobe, no command, no pull and no pin edge, `flags_o` holds its value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_we | input | 4 | Per-flag ALU write strobes {N,V,Z,C} |
| alu_val | input | 4 | ALU result flag values {N,V,Z,C} |
| i_set | input | 1 | Set interrupt-disable |
| i_clr | input | 1 | Clear interrupt-disable |
| d_set | input | 1 | Set decimal mode |
| d_clr | input | 1 | Clear decimal mode |
| pull_load | input | 1 | Load status from a pulled stack byte |
| pull_data | input | 8 | Pulled stack byte |
| so_n | input | 1 | Asynchronous active-low set-overflow pin |
| push_brk | input | 1 | Push source: 1 software break, 0 hardware interrupt |
| flags_o | output | 8 | Live status flags |
| push_img_o | output | 8 | Status byte to push on the stack |

## Verification
The overflow flag can be written by two functions in the same clock edge: the synchronized overflow-pin edge, and either an ALU overflow write or a stack pull. To make them collide, the bench counts the synchronizer latency from the cycle in which it drops `so_n`. It then places a clearing ALU write of V, and in a second run a pull of an all-zero byte, in exactly the cycle where the edge lands. The collision is judged correct when V reads 1 after that edge while the other pulled bits take their new values. It is also checked that the still-low pin does not set V again once V has been cleared.

// File: rtl/psr_pkg.sv
// Package psr_pkg
// Holds the bit positions of the status byte and the index map from the
// ALU flag vector {N,V,Z,C} to those positions. Assumes an 8-bit status byte.
package psr_pkg;
    localparam int PSR_W   = 8;
    localparam int ALU_W   = 4;
    localparam int BIT_C   = 0;
    localparam int BIT_Z   = 1;
    localparam int BIT_I   = 2;
    localparam int BIT_D   = 3;
    localparam int BIT_B   = 4;
    localparam int BIT_U   = 5;
    localparam int BIT_V   = 6;
    localparam int BIT_N   = 7;
    localparam int ALU_IDX_V = 2;

    // Position in the status byte of ALU flag index k ({N,V,Z,C} = 3..0).
    function automatic int alu_pos(input int k);
        case (k)
            0:       return BIT_C;
            1:       return BIT_Z;
            2:       return BIT_V;
            default: return BIT_N;
        endcase
    endfunction
endpackage

// File: rtl/psr_so_edge.sv
// Module psr_so_edge
// Synchronizes the asynchronous active-low set-overflow pin through
// SYNC_STAGES flops and flags one cycle per high-to-low transition.
// Assumes the pin idles high; all stages reset to 1 so no false edge
// follows reset.
module psr_so_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic so_n,
    output logic so_fall
);
    logic [SYNC_STAGES:0] chain;
    logic                 prev_q;

    assign chain[0] = so_n;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        // Purpose: one synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g+1] <= 1'b1;
            else        chain[g+1] <= chain[g];
        end
    end

    // Purpose: remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain[SYNC_STAGES];
    end

    assign so_fall = prev_q & ~chain[SYNC_STAGES];
endmodule

// File: rtl/psr_flag_core.sv
// Module psr_flag_core
// Stores the arithmetic flags {N,V,Z,C} and the mode bits {D,I}, and
// resolves every write source per bit.
// Precedence: pin edge (V only) > pull > ALU strobe or mode command > hold.
// Assumes the arithmetic flags need no reset (software initializes them).
module psr_flag_core
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALU_W-1:0] alu_we,
    input  logic [ALU_W-1:0] alu_val,
    input  logic             i_set,
    input  logic             i_clr,
    input  logic             d_set,
    input  logic             d_clr,
    input  logic             pull_load,
    input  logic [PSR_W-1:0] pull_data,
    input  logic             so_fall,
    output logic [PSR_W-1:0] flags
);
    logic [ALU_W-1:0] arith_q, arith_d;
    logic             d_q, i_q, d_nx, i_nx;
    logic             unused_pull_bits;

    assign unused_pull_bits = ^{pull_data[BIT_U], pull_data[BIT_B]};

    for (genvar k = 0; k < ALU_W; k++) begin : g_arith
        // Purpose: next value of one arithmetic flag.
        always_comb begin
            if (so_fall && k == ALU_IDX_V) arith_d[k] = 1'b1;
            else if (pull_load)            arith_d[k] = pull_data[alu_pos(k)];
            else if (alu_we[k])            arith_d[k] = alu_val[k];
            else                           arith_d[k] = arith_q[k];
        end
    end

    // Purpose: arithmetic flag storage, untouched by reset.
    always_ff @(posedge clk) begin
        arith_q <= arith_d;
    end

    // Purpose: next value of the mode bits; set beats clear.
    always_comb begin
        d_nx = d_q;
        i_nx = i_q;
        if (pull_load) begin
            d_nx = pull_data[BIT_D];
            i_nx = pull_data[BIT_I];
        end else begin
            if (d_set)      d_nx = 1'b1;
            else if (d_clr) d_nx = 1'b0;
            if (i_set)      i_nx = 1'b1;
            else if (i_clr) i_nx = 1'b0;
        end
    end

    // Purpose: mode bit storage; reset clears D and sets I.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= 1'b0;
            i_q <= 1'b1;
        end else begin
            d_q <= d_nx;
            i_q <= i_nx;
        end
    end

    // Purpose: assemble the live status byte with the fixed bits set.
    always_comb begin
        flags        = '0;
        flags[BIT_N] = arith_q[3];
        flags[BIT_V] = arith_q[ALU_IDX_V];
        flags[BIT_U] = 1'b1;
        flags[BIT_B] = 1'b1;
        flags[BIT_D] = d_q;
        flags[BIT_I] = i_q;
        flags[BIT_Z] = arith_q[1];
        flags[BIT_C] = arith_q[0];
    end
endmodule

// File: rtl/psr_push_fmt.sv
// Module psr_push_fmt
// Forms the byte pushed on the stack: the live flags with the break bit
// replaced by the push source. Purely combinational.
module psr_push_fmt
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0] flags,
    input  logic             push_brk,
    output logic [PSR_W-1:0] push_img
);
    // Purpose: substitute the break-source indication.
    always_comb begin
        push_img        = flags;
        push_img[BIT_B] = push_brk;
    end
endmodule

// File: rtl/cpu_status_reg.sv
// Module cpu_status_reg
// Top of the status flag register: pin synchronizer and edge detector,
// flag storage, and push image formatter.
// Assumes all inputs except so_n are synchronous to clk.
module cpu_status_reg #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] alu_we,
    input  logic [3:0] alu_val,
    input  logic       i_set,
    input  logic       i_clr,
    input  logic       d_set,
    input  logic       d_clr,
    input  logic       pull_load,
    input  logic [7:0] pull_data,
    input  logic       so_n,
    input  logic       push_brk,
    output logic [7:0] flags_o,
    output logic [7:0] push_img_o
);
    logic so_fall_w;

    psr_so_edge #(.SYNC_STAGES(SYNC_STAGES)) u_so_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .so_n    (so_n),
        .so_fall (so_fall_w)
    );

    psr_flag_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_we    (alu_we),
        .alu_val   (alu_val),
        .i_set     (i_set),
        .i_clr     (i_clr),
        .d_set     (d_set),
        .d_clr     (d_clr),
        .pull_load (pull_load),
        .pull_data (pull_data),
        .so_fall   (so_fall_w),
        .flags     (flags_o)
    );

    psr_push_fmt u_push (
        .flags    (flags_o),
        .push_brk (push_brk),
        .push_img (push_img_o)
    );
endmodule

// File: rtl/psr_checker.sv
// Module psr_checker
// Temporal checks on the status register, bound into cpu_status_reg.
module psr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_we_c,
    input logic       alu_val_c,
    input logic       i_set,
    input logic       pull_load,
    input logic [5:0] pull_keep,
    input logic       any_cmd,
    input logic       so_fall,
    input logic       push_brk,
    input logic [7:0] flags_o,
    input logic [7:0] push_img_o
);
    assert_reset_mode_R2: assert property (@(posedge clk)
        !rst_n |=> (flags_o[3] == 1'b0 && flags_o[2] == 1'b1));

    assert_alu_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we_c && !pull_load) |=> flags_o[0] == $past(alu_val_c));

    assert_iset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (i_set && !pull_load) |=> flags_o[2]);

    assert_pull_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_load && !so_fall) |=> {flags_o[7:6], flags_o[3:0]} == $past(pull_keep));

    assert_so_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        so_fall |=> flags_o[6]);

    assert_push_image_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_img_o[7:5] == flags_o[7:5] && push_img_o[3:0] == flags_o[3:0]
        && push_img_o[4] == push_brk);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_cmd && !so_fall && $past(rst_n)) |=> $stable(flags_o));
endmodule

bind cpu_status_reg psr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_we_c   (alu_we[0]),
    .alu_val_c  (alu_val[0]),
    .i_set      (i_set),
    .pull_load  (pull_load),
    .pull_keep  ({pull_data[7:6], pull_data[3:0]}),
    .any_cmd    ((|alu_we) | i_set | i_clr | d_set | d_clr | pull_load),
    .so_fall    (so_fall_w),
    .push_brk   (push_brk),
    .flags_o    (flags_o),
    .push_img_o (push_img_o)
);

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alu_we = '0;
    logic [3:0] alu_val = '0;
    logic       i_set = 1'b0, i_clr = 1'b0, d_set = 1'b0, d_clr = 1'b0;
    logic       pull_load = 1'b0;
    logic [7:0] pull_data = '0;
    logic       so_n = 1'b1;
    logic       push_brk = 1'b0;
    logic [7:0] flags_o, push_img_o;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cpu_status_reg u_cpu_status_reg (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_val(alu_val),
        .i_set(i_set), .i_clr(i_clr), .d_set(d_set), .d_clr(d_clr),
        .pull_load(pull_load), .pull_data(pull_data), .so_n(so_n),
        .push_brk(push_brk), .flags_o(flags_o), .push_img_o(push_img_o)
    );

    // Vector: {we[4], val[4], {i_set,i_clr,d_set,d_clr}[4], pull, pdata[8], expected flags[8]}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {4'hF, 4'h0, 4'h0, 1'b0, 8'h00, 8'h34},  // R3 clear all arithmetic
        {4'h1, 4'h1, 4'h0, 1'b0, 8'h00, 8'h35},  // R3 set C only
        {4'hA, 4'hF, 4'h0, 1'b0, 8'h00, 8'hB7},  // R3 N and Z strobed, V/C masked
        {4'h0, 4'h0, 4'h6, 1'b0, 8'h00, 8'hBB},  // R4 clear I, set D
        {4'h4, 4'h4, 4'h9, 1'b0, 8'h00, 8'hF7},  // R3 R4 set V, set I, clear D
        {4'h0, 4'h0, 4'h3, 1'b0, 8'h00, 8'hFF},  // R4 set and clear D: set wins
        {4'h0, 4'h0, 4'h0, 1'b1, 8'h00, 8'h30},  // R5 pull zero, fixed bits stay
        {4'hF, 4'hF, 4'hA, 1'b1, 8'hC3, 8'hF3},  // R5 pull beats ALU and mode
        {4'h0, 4'h0, 4'h0, 1'b1, 8'h0C, 8'h3C},  // R5 pull D and I only
        {4'h0, 4'h0, 4'h0, 1'b0, 8'h00, 8'h3C}   // R9 idle holds
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        alu_we = '0; alu_val = '0; i_set = 0; i_clr = 0; d_set = 0; d_clr = 0;
        pull_load = 0; pull_data = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        check("R2 R1 reset mode and fixed bits", flags_o & 8'h3C, 8'h34);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            alu_we    = VEC[i][28:25];
            alu_val   = VEC[i][24:21];
            {i_set, i_clr, d_set, d_clr} = VEC[i][20:17];
            pull_load = VEC[i][16];
            pull_data = VEC[i][15:8];
            tick();
            check($sformatf("R3/R4/R5/R9 vector %0d", i), flags_o, VEC[i][7:0]);
        end
        idle_inputs();

        // R2: reset touches only D and I.
        alu_we = 4'h9; alu_val = 4'h9;
        tick();
        idle_inputs();
        check("R3 N and C set before reset", flags_o, 8'hBD);
        rst_n = 1'b0;
        tick();
        tick();
        check("R2 during reset arithmetic retained", flags_o, 8'hB5);
        rst_n = 1'b1;
        tick();
        check("R2 after reset", flags_o, 8'hB5);

        // R6: pin latency and single set.
        so_n = 1'b0;
        tick();
        check("R6 V after first edge", {7'd0, flags_o[6]}, 8'h00);
        tick();
        check("R6 V after second edge", {7'd0, flags_o[6]}, 8'h00);
        tick();
        check("R6 V after third edge", {7'd0, flags_o[6]}, 8'h01);
        alu_we = 4'h4; alu_val = 4'h0;
        tick();
        idle_inputs();
        repeat (3) tick();
        check("R6 held low sets once", {7'd0, flags_o[6]}, 8'h00);

        // R7: pin edge against ALU write of V.
        so_n = 1'b1;
        repeat (3) tick();
        so_n = 1'b0;
        tick();
        tick();
        alu_we = 4'h4; alu_val = 4'h0;
        tick();
        idle_inputs();
        check("R7 edge beats ALU clear of V", {7'd0, flags_o[6]}, 8'h01);

        // R7: pin edge against pull.
        alu_we = 4'h4; alu_val = 4'h0;
        tick();
        idle_inputs();
        so_n = 1'b1;
        repeat (3) tick();
        so_n = 1'b0;
        tick();
        tick();
        pull_load = 1'b1; pull_data = 8'h00;
        tick();
        idle_inputs();
        check("R7 edge beats pull for V", flags_o, 8'h70);

        // R8: push image break source.
        push_brk = 1'b1;
        #1;
        check("R8 push image software break", push_img_o, 8'h70);
        push_brk = 1'b0;
        #1;
        check("R8 push image hardware interrupt", push_img_o, 8'h60);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule